// File: doc/BRIEF.md
# Protection Configuration Register File

This block stores the configuration side of a region-based memory protection unit. It keeps a bank of entries, each made of an 8-bit configuration byte and an address register one machine word wide. Software reaches the bank through a single CSR-style request port. A request carries a select that picks either a packed configuration word or one address register, plus an index and write data. Several configuration bytes share each configuration word, one byte per lane.

Each configuration byte carries a lock flag and a two-bit match-mode field. A set lock flag freezes the byte and the address register of its own entry. The address register of an entry is also frozen when the entry directly above it is locked and uses top-of-range matching. Writes that would touch a frozen entry or a non-existent index are dropped without side effects. A one-cycle strobe reports each dropped write.

The raw configuration and address arrays are exported flat for the range-matching logic downstream. The block also exports a registered count of entries whose mode is not off. A two-state controller keeps that count current: ST_IDLE while no recount is pending, and ST_RECOUNT in the cycle after any write that stored something. The transitions are ST_IDLE to ST_RECOUNT on an accepted write, ST_RECOUNT to itself on a further accepted write, and ST_RECOUNT back to ST_IDLE otherwise. The block decodes no ranges and checks no permissions.

Top module: `prot_cfg_regfile`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every configuration byte, every address register, active_count, wr_ignored and rsp_rdata to zero.
- R2: A configuration write (req_sel=0) to word index n with BPW=XLEN/8 byte lanes stores lane k (req_wdata bits 8k+7..8k) into entry n*BPW+k at the next edge, provided that entry is unlocked. A configuration read of word n returns the same packing, with entry n*BPW+k in lane k.
- R3: The lock flag is bit 7 of a configuration byte. A lane whose entry has the lock flag set keeps its old byte, while unlocked lanes of the same write are still stored. Therefore a set lock flag can only be cleared by reset.
- R4: An address write (req_sel=1) to entry i stores req_wdata at the next edge when entry i is writable, and an address read of entry i returns that value.
- R5: An address write to an entry whose own lock flag is set leaves every address register unchanged.
- R6: The match mode is held in bits 4..3 of a configuration byte (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power-of-two). An address write to entry i is dropped when entry i+1 has its lock flag set and mode 1. A locked entry i+1 with any other mode does not protect entry i. The top entry has no neighbour above, and no check wraps to entry 0.
- R7: Writes to a configuration word index at or above ceil(NUM_ENTRIES/BPW), or to an address index at or above NUM_ENTRIES, change nothing. Reads of such indices return zero.
- R8: With XLEN=64, a write to any odd configuration word index changes nothing and is reported as dropped. Reads of odd indices are not blocked.
- R9: active_count changes only in the cycle after the state is ST_RECOUNT. One edge after an accepted write it equals the number of entries whose mode field is not 0.
- R10: wr_ignored is high for exactly the one cycle after a write in which any lane or the address was dropped (lock, out-of-range index or odd wide index). It is low after reads, after idle cycles and after fully accepted writes.
- R11: rsp_rdata is registered. It shows the read result one edge after a read request and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 1 | 0 selects a packed configuration word, 1 selects an address register |
| req_index | input | IDX_W | Word index (configuration) or entry index (address) |
| req_wdata | input | XLEN | Write data |
| rsp_rdata | output | XLEN | Registered read data |
| wr_ignored | output | 1 | One-cycle pulse after a dropped write |
| active_count | output | $clog2(NUM_ENTRIES+1) | Registered count of entries whose mode is not off |
| cfg_flat | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7..8e |
| addr_flat | output | NUM_ENTRIES*XLEN | All address registers, entry e at bits XLEN*(e+1)-1..XLEN*e |

## Verification
The bench aims at the neighbour rule. It locks an entry in top-of-range mode and another in a different mode, then writes the address just below each. A design that ignored the neighbour would overwrite a protected address. A design that applied the rule to every mode would refuse a legal write, and one that wrapped the top entry onto entry 0 would refuse the write to entry 0.

It also sends a configuration word that mixes locked and unlocked lanes. A whole-word lock would lose the unlocked lanes, and a missing per-lane lock would clear a lock flag. Out-of-range indices, the odd-index rule on a 64-bit instance and the one-cycle lag of the active count are all checked. A mistake there shows up as stray data, a missing or stretched strobe, or a count that moves a cycle early or late.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

    localparam int CFG_BYTE_W = 8;
    localparam int LOCK_BIT   = 7;
    localparam int MODE_LSB   = 3;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RECOUNT = 1'b1
    } rf_state_e;

    function automatic match_mode_e byte_mode(input logic [CFG_BYTE_W-1:0] b);
        return match_mode_e'(b[MODE_LSB +: 2]);
    endfunction

    function automatic logic byte_locked(input logic [CFG_BYTE_W-1:0] b);
        return b[LOCK_BIT];
    endfunction

endpackage

// File: rtl/prot_lock_eval.sv
module prot_lock_eval
    import prot_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES*CFG_BYTE_W-1:0] cfg_flat,
    output logic [NUM_ENTRIES-1:0]            cfg_lock,
    output logic [NUM_ENTRIES-1:0]            addr_lock
);

    genvar e;
    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_ent
            logic [CFG_BYTE_W-1:0] own_byte;
            assign own_byte    = cfg_flat[e*CFG_BYTE_W +: CFG_BYTE_W];
            assign cfg_lock[e] = byte_locked(own_byte);
            if (e < NUM_ENTRIES - 1) begin : g_has_next
                logic [CFG_BYTE_W-1:0] next_byte;
                assign next_byte    = cfg_flat[(e+1)*CFG_BYTE_W +: CFG_BYTE_W];
                assign addr_lock[e] = byte_locked(own_byte) ||
                                      (byte_locked(next_byte) && (byte_mode(next_byte) == MATCH_TOR));
            end else begin : g_top
                assign addr_lock[e] = byte_locked(own_byte);
            end
        end
    endgenerate

endmodule

// File: rtl/prot_cfg_lane_wr.sv
module prot_cfg_lane_wr #(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32
) (
    input  logic                   wr_cfg,
    input  logic [31:0]            idx_w,
    input  logic [NUM_ENTRIES-1:0] cfg_lock,
    output logic [NUM_ENTRIES-1:0] lane_we,
    output logic                   cfg_drop
);

    localparam int BPW       = XLEN / 8;
    localparam bit ODD_GUARD = (XLEN == 64);

    logic odd_blocked;
    assign odd_blocked = ODD_GUARD && idx_w[0];

    genvar e;
    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_we
            assign lane_we[e] = wr_cfg && !odd_blocked &&
                                (idx_w == 32'(e / BPW)) && !cfg_lock[e];
        end
    endgenerate

    always_comb begin
        cfg_drop = 1'b0;
        if (wr_cfg) begin
            if (odd_blocked) begin
                cfg_drop = 1'b1;
            end else begin
                for (int k = 0; k < BPW; k++) begin
                    if ((idx_w * 32'(BPW)) + 32'(k) >= 32'(NUM_ENTRIES)) begin
                        cfg_drop = 1'b1;
                    end
                end
                for (int n = 0; n < NUM_ENTRIES; n++) begin
                    if ((idx_w == 32'(n / BPW)) && cfg_lock[n]) begin
                        cfg_drop = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/prot_active_count.sv
module prot_active_count
    import prot_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES*CFG_BYTE_W-1:0]     cfg_flat,
    output logic [$clog2(NUM_ENTRIES+1)-1:0]      live_count
);

    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    logic [NUM_ENTRIES-1:0] active_vec;

    genvar e;
    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_act
            assign active_vec[e] =
                byte_mode(cfg_flat[e*CFG_BYTE_W +: CFG_BYTE_W]) != MATCH_OFF;
        end
    endgenerate

    always_comb begin
        live_count = '0;
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            live_count = live_count + CNT_W'(active_vec[n]);
        end
    end

endmodule

// File: rtl/prot_cfg_regfile.sv
module prot_cfg_regfile
    import prot_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic                              req_sel,
    input  logic [IDX_W-1:0]                  req_index,
    input  logic [XLEN-1:0]                   req_wdata,
    output logic [XLEN-1:0]                   rsp_rdata,
    output logic                              wr_ignored,
    output logic [$clog2(NUM_ENTRIES+1)-1:0]  active_count,
    output logic [NUM_ENTRIES*8-1:0]          cfg_flat,
    output logic [NUM_ENTRIES*XLEN-1:0]       addr_flat
);

    localparam int BPW   = XLEN / CFG_BYTE_W;
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    logic [CFG_BYTE_W-1:0] cfg_q  [NUM_ENTRIES];
    logic [XLEN-1:0]       addr_q [NUM_ENTRIES];

    rf_state_e st_q, st_d;

    logic [31:0]            idx_w;
    logic                   wr_cfg, wr_addr, rd_req;
    logic [NUM_ENTRIES-1:0] cfg_lock, addr_lock;
    logic [NUM_ENTRIES-1:0] lane_we, addr_we, addr_hit;
    logic                   cfg_drop, addr_drop, wr_accept;
    logic [CNT_W-1:0]       live_count;
    logic [XLEN-1:0]        rd_mux;

    assign idx_w   = 32'(req_index);
    assign wr_cfg  = req_valid && req_write && !req_sel;
    assign wr_addr = req_valid && req_write &&  req_sel;
    assign rd_req  = req_valid && !req_write;

    // Flatten the storage for the downstream matcher
    genvar e;
    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_flat
            assign cfg_flat[e*CFG_BYTE_W +: CFG_BYTE_W] = cfg_q[e];
            assign addr_flat[e*XLEN +: XLEN]            = addr_q[e];
            assign addr_hit[e] = (idx_w == 32'(e));
            assign addr_we[e]  = wr_addr && addr_hit[e] && !addr_lock[e];
        end
    endgenerate

    prot_lock_eval #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_lock (
        .cfg_flat  (cfg_flat),
        .cfg_lock  (cfg_lock),
        .addr_lock (addr_lock)
    );

    prot_cfg_lane_wr #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .XLEN        (XLEN)
    ) u_lane (
        .wr_cfg   (wr_cfg),
        .idx_w    (idx_w),
        .cfg_lock (cfg_lock),
        .lane_we  (lane_we),
        .cfg_drop (cfg_drop)
    );

    prot_active_count #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_cnt (
        .cfg_flat   (cfg_flat),
        .live_count (live_count)
    );

    // An address write is dropped when no entry matches or the entry is frozen
    assign addr_drop = wr_addr && ((addr_hit == '0) || ((addr_hit & addr_lock) != '0));
    assign wr_accept = (lane_we != '0) || (addr_we != '0);

    // Storage update
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                cfg_q[n]  <= '0;
                addr_q[n] <= '0;
            end
        end else begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (lane_we[n]) begin
                    cfg_q[n] <= req_wdata[(n % BPW)*CFG_BYTE_W +: CFG_BYTE_W];
                end
                if (addr_we[n]) begin
                    addr_q[n] <= req_wdata;
                end
            end
        end
    end

    // Read assembly: lane k of word n carries entry n*BPW+k
    always_comb begin
        rd_mux = '0;
        if (!req_sel) begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (idx_w == 32'(n / BPW)) begin
                    rd_mux[(n % BPW)*CFG_BYTE_W +: CFG_BYTE_W] = cfg_q[n];
                end
            end
        end else begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (addr_hit[n]) begin
                    rd_mux = addr_q[n];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
        end else if (rd_req) begin
            rsp_rdata <= rd_mux;
        end
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Controller: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    st_d = wr_accept ? ST_RECOUNT : ST_IDLE;
            ST_RECOUNT: st_d = wr_accept ? ST_RECOUNT : ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Controller: outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            active_count <= '0;
            wr_ignored   <= 1'b0;
        end else begin
            wr_ignored <= cfg_drop || addr_drop;
            unique case (st_q)
                ST_IDLE:    active_count <= active_count;
                ST_RECOUNT: active_count <= live_count;
                default:    active_count <= active_count;
            endcase
        end
    end

endmodule

// File: rtl/prot_cfg_regfile_chk.sv
module prot_cfg_regfile_chk
    import prot_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 6
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              req_valid,
    input logic                              req_write,
    input logic                              req_sel,
    input logic [IDX_W-1:0]                  req_index,
    input logic [XLEN-1:0]                   rsp_rdata,
    input logic                              wr_ignored,
    input logic [$clog2(NUM_ENTRIES+1)-1:0]  active_count,
    input logic [NUM_ENTRIES*8-1:0]          cfg_flat,
    input logic [NUM_ENTRIES*XLEN-1:0]       addr_flat,
    input rf_state_e                         st_q
);

    localparam int BPW       = XLEN / 8;
    localparam int CFG_WORDS = (NUM_ENTRIES + BPW - 1) / BPW;

    logic [31:0]            idx_w;
    logic [NUM_ENTRIES-1:0] own_lock, next_tor;
    logic                   sel_own, sel_tor, oob_read;

    assign idx_w = 32'(req_index);

    genvar e;
    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_vec
            assign own_lock[e] = cfg_flat[e*8 + LOCK_BIT];
            if (e < NUM_ENTRIES - 1) begin : g_nx
                assign next_tor[e] = cfg_flat[(e+1)*8 + LOCK_BIT] &&
                                     (cfg_flat[(e+1)*8 + MODE_LSB +: 2] == MATCH_TOR);
            end else begin : g_top
                assign next_tor[e] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        sel_own = 1'b0;
        sel_tor = 1'b0;
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            if (idx_w == 32'(n)) begin
                sel_own = own_lock[n];
                sel_tor = next_tor[n];
            end
        end
    end

    assign oob_read = req_valid && !req_write &&
                      ((req_sel && (idx_w >= 32'(NUM_ENTRIES))) ||
                       (!req_sel && (idx_w >= 32'(CFG_WORDS))));

    generate
        for (e = 0; e < NUM_ENTRIES; e++) begin : g_sticky
            // R3
            lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
                cfg_flat[e*8 + LOCK_BIT] |=> cfg_flat[e*8 + LOCK_BIT]);
        end
    endgenerate

    // R5
    own_lock_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_sel && sel_own) |=> $stable(addr_flat));

    // R6
    tor_lock_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_sel && sel_tor) |=> $stable(addr_flat));

    // R7
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        oob_read |=> (rsp_rdata == '0));

    // R9
    count_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_count) |-> ($past(st_q) == ST_RECOUNT));

    // R10
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ignored |-> $past(req_valid && req_write));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> $stable(rsp_rdata));

    // R2
    addr_write_cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_sel) |=> $stable(cfg_flat));

endmodule

bind prot_cfg_regfile prot_cfg_regfile_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .XLEN        (XLEN),
    .IDX_W       (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_sel      (req_sel),
    .req_index    (req_index),
    .rsp_rdata    (rsp_rdata),
    .wr_ignored   (wr_ignored),
    .active_count (active_count),
    .cfg_flat     (cfg_flat),
    .addr_flat    (addr_flat),
    .st_q         (st_q)
);

// File: tb/prot_cfg_regfile_bench.sv
`timescale 1ns/1ps
module prot_cfg_regfile_bench;

    localparam int N  = 16;
    localparam int XL = 32;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // main instance
    logic          rv = 1'b0, rw = 1'b0, rs = 1'b0;
    logic [IW-1:0] ri = '0;
    logic [XL-1:0] wd = '0;
    logic [XL-1:0] rdata;
    logic          ign;
    logic [4:0]    cnt;
    logic [N*8-1:0]  cfgv;
    logic [N*XL-1:0] addrv;

    prot_cfg_regfile #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) u_prot_cfg_regfile (
        .clk(clk), .rst(rst), .req_valid(rv), .req_write(rw), .req_sel(rs),
        .req_index(ri), .req_wdata(wd), .rsp_rdata(rdata), .wr_ignored(ign),
        .active_count(cnt), .cfg_flat(cfgv), .addr_flat(addrv));

    // wide instance
    logic          wv = 1'b0, ww = 1'b0, ws = 1'b0;
    logic [IW-1:0] wi = '0;
    logic [63:0]   wwd = '0;
    logic [63:0]   w_rdata;
    logic          w_ign;
    logic [4:0]    w_cnt;
    logic [N*8-1:0]  w_cfg;
    logic [N*64-1:0] w_addr;

    prot_cfg_regfile #(.NUM_ENTRIES(N), .XLEN(64), .IDX_W(IW)) u_wide (
        .clk(clk), .rst(rst), .req_valid(wv), .req_write(ww), .req_sel(ws),
        .req_index(wi), .req_wdata(wwd), .rsp_rdata(w_rdata), .wr_ignored(w_ign),
        .active_count(w_cnt), .cfg_flat(w_cfg), .addr_flat(w_addr));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model
    logic [7:0]    m_cfg  [N];
    logic [XL-1:0] m_addr [N];
    int            m_count;
    bit            m_pend, m_ign, m_acc, m_drop;
    logic [XL-1:0] m_rd;

    function automatic int mode_of(input logic [7:0] b);
        return int'(b[4:3]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < N; n++) begin m_cfg[n] = '0; m_addr[n] = '0; end
            m_count = 0; m_pend = 0; m_ign = 0; m_rd = '0;
        end else begin
            if (m_pend) begin
                m_count = 0;
                for (int n = 0; n < N; n++) if (mode_of(m_cfg[n]) != 0) m_count++;
            end
            m_acc = 0; m_drop = 0;
            if (rv && !rw) begin
                m_rd = '0;
                if (!rs) begin
                    for (int k = 0; k < 4; k++)
                        if (int'(ri)*4 + k < N) m_rd[k*8 +: 8] = m_cfg[int'(ri)*4 + k];
                end else if (int'(ri) < N) begin
                    m_rd = m_addr[int'(ri)];
                end
            end
            if (rv && rw) begin
                if (!rs) begin
                    for (int k = 0; k < 4; k++) begin
                        if (int'(ri)*4 + k >= N) m_drop = 1;
                        else if (m_cfg[int'(ri)*4 + k][7]) m_drop = 1;
                        else begin m_cfg[int'(ri)*4 + k] = wd[k*8 +: 8]; m_acc = 1; end
                    end
                end else begin
                    if (int'(ri) >= N) m_drop = 1;
                    else if (m_cfg[int'(ri)][7]) m_drop = 1;
                    else if (int'(ri) < N-1 && m_cfg[int'(ri)+1][7] && mode_of(m_cfg[int'(ri)+1]) == 1) m_drop = 1;
                    else begin m_addr[int'(ri)] = wd; m_acc = 1; end
                end
            end
            m_pend = m_acc;
            m_ign  = m_drop;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int bad_c, bad_a;
            bad_c = -1; bad_a = -1;
            for (int n = N-1; n >= 0; n--) begin
                if (cfgv[n*8 +: 8] !== m_cfg[n]) bad_c = n;
                if (addrv[n*XL +: XL] !== m_addr[n]) bad_a = n;
            end
            if (bad_c < 0) check(1, "R2 R3 cfg", 0, 0);
            else check(0, "R2 R3 cfg entry", 64'(cfgv[bad_c*8 +: 8]), 64'(m_cfg[bad_c]));
            if (bad_a < 0) check(1, "R4 R5 R6 addr", 0, 0);
            else check(0, "R4 R5 R6 addr entry", 64'(addrv[bad_a*XL +: XL]), 64'(m_addr[bad_a]));
            check(int'(cnt) == m_count, "R9 count", 64'(cnt), 64'(m_count));
            check(ign === m_ign, "R10 strobe", 64'(ign), 64'(m_ign));
            check(rdata === m_rd, "R11 rdata", 64'(rdata), 64'(m_rd));
        end
    end

    task automatic req(input bit wr, input bit sel, input int idx, input logic [XL-1:0] data);
        @(negedge clk);
        rv = 1'b1; rw = wr; rs = sel; ri = IW'(idx); wd = data;
        @(negedge clk);
        rv = 1'b0; rw = 1'b0;
    endtask

    task automatic wreq(input bit wr, input bit sel, input int idx, input logic [63:0] data);
        @(negedge clk);
        wv = 1'b1; ww = wr; ws = sel; wi = IW'(idx); wwd = data;
        @(negedge clk);
        wv = 1'b0; ww = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(cfgv == '0 && addrv == '0, "R1 arrays", 64'(cfgv[63:0]), 0);
        check(cnt == 0 && ign == 0 && rdata == 0, "R1 outputs", 64'({cnt, ign}), 0);

        // R2 packed write, R9 lag
        req(1, 0, 0, 32'h0018_1008);
        check(cfgv[31:0] == 32'h0018_1008, "R2 lanes", 64'(cfgv[31:0]), 64'h0018_1008);
        check(cnt == 0, "R9 not yet", 64'(cnt), 0);
        idle(1);
        check(cnt == 3, "R9 count", 64'(cnt), 3);

        // R4 address write and read
        req(1, 1, 5, 32'h0000_1234);
        req(0, 1, 5, 0);
        check(rdata == 32'h1234, "R4 R11 read", 64'(rdata), 64'h1234);
        // top entry, no neighbour
        req(1, 1, 15, 32'h0000_F0F0);
        check(addrv[15*XL +: XL] == 32'hF0F0, "R6 top entry", 64'(addrv[15*XL +: XL]), 64'hF0F0);

        // locks: e5 locked TOR, e6 locked NA4, e9 locked NAPOT, e15 locked TOR
        req(1, 0, 1, 32'h0090_8800);
        req(1, 0, 2, 32'h0000_9800);
        req(1, 0, 3, 32'h8800_0000);
        idle(1);
        check(cnt == 7, "R9 count after locks", 64'(cnt), 7);

        req(1, 1, 4, 32'h0000_AAAA);
        check(addrv[4*XL +: XL] == 0 && ign == 1, "R6 neighbour tor lock", 64'(addrv[4*XL +: XL]), 0);
        req(1, 1, 5, 32'h0000_BBBB);
        check(addrv[5*XL +: XL] == 32'h1234 && ign == 1, "R5 own lock", 64'(addrv[5*XL +: XL]), 64'h1234);
        req(1, 1, 8, 32'h0000_8888);
        check(addrv[8*XL +: XL] == 32'h8888 && ign == 0, "R6 non tor neighbour", 64'(addrv[8*XL +: XL]), 64'h8888);
        req(1, 1, 0, 32'h0000_0100);
        check(addrv[0 +: XL] == 32'h100, "R6 no wrap", 64'(addrv[0 +: XL]), 64'h100);
        req(1, 1, 14, 32'h0000_EEEE);
        check(addrv[14*XL +: XL] == 0, "R6 below top", 64'(addrv[14*XL +: XL]), 0);

        // R3 mixed lanes
        req(1, 0, 1, 32'h1F1F_1F1F);
        check(ign == 1, "R3 R10 strobe", 64'(ign), 1);
        req(0, 0, 1, 0);
        check(rdata == 32'h1F90_881F, "R3 R2 mixed", 64'(rdata), 64'h1F90_881F);
        check(ign == 0, "R10 read no strobe", 64'(ign), 0);

        // R7 out of range
        req(1, 0, 4, 32'hFFFF_FFFF);
        check(ign == 1, "R7 cfg oob write", 64'(ign), 1);
        req(0, 0, 4, 0);
        check(rdata == 0, "R7 cfg oob read", 64'(rdata), 0);
        req(1, 1, 16, 32'h5555_5555);
        check(ign == 1, "R7 addr oob write", 64'(ign), 1);
        req(0, 1, 8, 0);
        req(0, 1, 63, 0);
        check(rdata == 0, "R7 addr oob read", 64'(rdata), 0);
        req(0, 1, 8, 0);
        idle(3);
        check(rdata == 32'h8888 && ign == 0, "R11 hold", 64'(rdata), 64'h8888);

        // R8 wide instance
        wreq(1, 0, 0, 64'h8877_6655_4433_2211);
        check(w_cfg[63:0] == 64'h8877_6655_4433_2211 && w_ign == 0, "R2 wide", w_cfg[63:0], 64'h8877_6655_4433_2211);
        idle(1);
        check(w_cnt == 5, "R9 wide count", 64'(w_cnt), 5);
        wreq(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        check(w_ign == 1 && w_cfg[127:64] == 0, "R8 odd index", w_cfg[127:64], 0);
        wreq(0, 0, 1, 0);
        check(w_rdata == 0, "R8 odd read", w_rdata, 0);
        wreq(1, 0, 2, 64'h1);
        check(w_ign == 1, "R7 wide oob", 64'(w_ign), 1);

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule